// File: doc/BRIEF.md
# Serially Configured Two-Plane Logic Array with Output Inversion

This block is a small field-configurable logic array. Three primary inputs feed a plane of four product terms. Each term can use each input as a true literal, as a complemented literal, or not at all. A second plane lets every product term drive the OR gate of every output. A per-output inversion bit then flips each sum, so an output can be a sum of products or its complement. The evaluation path from the inputs to the outputs holds no register.

Configuration arrives one bit per clock on a serial chain while a load-enable is high. The bits collect in a staging register. A single-cycle commit pulse copies the staged word into the active configuration in one step. The logic therefore never evaluates a half-loaded word. A typical user shifts in a complete word, pulses commit, and from then on treats the block as fixed combinational logic until it is reprogrammed.

Top module: `pla_core`

## Requirements
- R1: The synchronous active-low reset clears both the staging and the active configuration. Every output is then 0 for all eight input values, and a commit that follows with nothing shifted keeps all outputs at 0.
- R2: A product term includes input i in true form when its true-literal bit is set and in complemented form when its complement bit is set. A term with no literal bit set evaluates to 1.
- R3: A product term whose true and complement bits are both set for the same input evaluates to 0 for every input value.
- R4: Any product term can be routed to any output through its connection bit. An output with no connection bits set has a sum of 0 before inversion.
- R5: When an output's inversion bit is set, that output is the complement of its sum of products.
- R6: While load_en is high, each rising clock edge shifts cfg_sdi into bit 0 of the 39-bit staging word, so the first bit sent ends at bit 38. The word layout is: bit o = inversion bit of output o (0..2); bit 3+3t+o = connection of term t (0..3) to output o; bit 15+6t+2i = true literal of input i in term t; bit 16+6t+2i = complement literal of input i in term t. Input i is in_vec[i], with A = in_vec[2], B = in_vec[1] and C = in_vec[0].
- R7: The active configuration changes only on a clock edge where commit is high, and then takes the staging word held before that edge. Shifting without commit leaves all outputs unchanged.
- R8: out_vec follows a change of in_vec without waiting for a clock edge.
- R9: With four terms the array realises F1 = A·B' + A·C + A'·B·C' on out_vec[0] and F2 = (A·C + B·C)' on out_vec[1] for all eight input values.
- R10: With four shared terms and inversion the array realises the minterm sets {3,5,6,7} on out_vec[0] and {1,2,3,7} on out_vec[1] for all eight input values, where the minterm index is in_vec read as an unsigned number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Shift enable for the serial configuration chain |
| cfg_sdi | input | 1 | Serial configuration data, most significant bit first |
| commit | input | 1 | One-cycle pulse that copies the staged word into the active configuration |
| in_vec | input | 3 | Primary logic inputs (A on bit 2, C on bit 0) |
| out_vec | output | 3 | Logic outputs after the inversion stage |

## Verification
The bench steps a single literal through every term, input, polarity and output position. A design with the word layout scrambled, or with a shift direction reversed, then lights the wrong output or the wrong literal. It programs a term with both literals of one input, which a design that treats the pair as a don't-care would evaluate to 1, and a term with no literals, which a design with the wrong identity would evaluate to 0. It shifts a new word without commit and checks that the outputs keep the old function, which catches a design that exposes the staging register. It also pulses commit after a reset with nothing shifted, which catches a reset that clears only the active copy.

// File: rtl/pla_pkg.sv
// Package: shared defaults and configuration-word layout helpers for the
// two-plane logic array. Assumes every caller passes the same dimensions.
package pla_pkg;

    localparam int unsigned PLA_IN_DEF   = 3;
    localparam int unsigned PLA_TERM_DEF = 4;
    localparam int unsigned PLA_OUT_DEF  = 3;

    // Total configuration bits: inversion, connection plane, literal plane
    function automatic int unsigned pla_cfg_width(input int unsigned n_in,
                                                  input int unsigned n_term,
                                                  input int unsigned n_out);
        return n_out + n_term * n_out + 2 * n_in * n_term;
    endfunction

    // Bit position of the inversion bit of output o
    function automatic int unsigned pla_pol_pos(input int unsigned o);
        return o;
    endfunction

    // Bit position of the connection of term t to output o
    function automatic int unsigned pla_conn_pos(input int unsigned n_out,
                                                 input int unsigned t,
                                                 input int unsigned o);
        return n_out + t * n_out + o;
    endfunction

    // Bit position of a literal of input i in term t (neg=1: complement)
    function automatic int unsigned pla_lit_pos(input int unsigned n_in,
                                                input int unsigned n_term,
                                                input int unsigned n_out,
                                                input int unsigned t,
                                                input int unsigned i,
                                                input int unsigned neg);
        return n_out + n_term * n_out + t * 2 * n_in + 2 * i + neg;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
// Module: serial configuration chain with a staging register and an active
// copy. Assumes commit is a single-cycle pulse; the active copy is the only
// state the logic planes see, so a partial shift is never visible.
module pla_cfg_chain #(
    parameter int unsigned CFG_W = 39
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cfg_sdi,
    input  logic             commit,
    output logic [CFG_W-1:0] shadow_q,
    output logic [CFG_W-1:0] active_q
);

    // Staging register: shift one bit in at the bottom per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (load_en) begin
            shadow_q <= {shadow_q[CFG_W-2:0], cfg_sdi};
        end
    end

    // Active register: take the whole staged word on a commit pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (commit) begin
            active_q <= shadow_q;
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
// Module: programmable AND plane. Each term ANDs the selected literals.
// Assumes lit_true/lit_comp are packed term-major (term t at t*N_IN).
// An empty term gives 1; both literals of one input give 0.
module pla_and_plane #(
    parameter int unsigned N_IN   = 3,
    parameter int unsigned N_TERM = 4
) (
    input  logic [N_IN-1:0]        in_vec,
    input  logic [N_TERM*N_IN-1:0] lit_true,
    input  logic [N_TERM*N_IN-1:0] lit_comp,
    output logic [N_TERM-1:0]      term_vec
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] sel_t;
        logic [N_IN-1:0] sel_c;
        assign sel_t = lit_true[t*N_IN +: N_IN];
        assign sel_c = lit_comp[t*N_IN +: N_IN];

        // Product: an unselected literal contributes 1
        always_comb begin
            term_vec[t] = &((in_vec | ~sel_t) & (~in_vec | ~sel_c));
        end
    end

endmodule

// File: rtl/pla_or_plane.sv
// Module: programmable OR plane followed by the per-output inversion.
// Assumes conn is packed output-major (output o at o*N_TERM). An output
// with no connections has a sum of 0.
module pla_or_plane #(
    parameter int unsigned N_TERM = 4,
    parameter int unsigned N_OUT  = 3
) (
    input  logic [N_TERM-1:0]       term_vec,
    input  logic [N_OUT*N_TERM-1:0] conn,
    input  logic [N_OUT-1:0]        pol,
    output logic [N_OUT-1:0]        sum_vec,
    output logic [N_OUT-1:0]        out_vec
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Sum of the connected terms
        always_comb begin
            sum_vec[o] = |(term_vec & conn[o*N_TERM +: N_TERM]);
        end

        // Optional inversion of the sum
        always_comb begin
            out_vec[o] = sum_vec[o] ^ pol[o];
        end
    end

endmodule

// File: rtl/pla_core.sv
// Module: top of the serially configured two-plane logic array. Unpacks
// the active configuration word into the literal, connection and
// inversion fields and wires the planes. Inputs to outputs is combinational.
module pla_core #(
    parameter int unsigned N_IN   = pla_pkg::PLA_IN_DEF,
    parameter int unsigned N_TERM = pla_pkg::PLA_TERM_DEF,
    parameter int unsigned N_OUT  = pla_pkg::PLA_OUT_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            cfg_sdi,
    input  logic            commit,
    input  logic [N_IN-1:0] in_vec,
    output logic [N_OUT-1:0] out_vec
);

    import pla_pkg::*;

    localparam int unsigned CFG_W = pla_cfg_width(N_IN, N_TERM, N_OUT);

    logic [CFG_W-1:0]        shadow_cfg;
    logic [CFG_W-1:0]        active_cfg;
    logic [N_TERM*N_IN-1:0]  lit_true;
    logic [N_TERM*N_IN-1:0]  lit_comp;
    logic [N_OUT*N_TERM-1:0] conn;
    logic [N_OUT-1:0]        pol;
    logic [N_TERM-1:0]       term_vec;
    logic [N_OUT-1:0]        sum_vec;

    pla_cfg_chain #(.CFG_W(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .cfg_sdi  (cfg_sdi),
        .commit   (commit),
        .shadow_q (shadow_cfg),
        .active_q (active_cfg)
    );

    // Field extraction from the active word
    for (genvar t = 0; t < N_TERM; t++) begin : g_lit_t
        for (genvar i = 0; i < N_IN; i++) begin : g_lit_i
            assign lit_true[t*N_IN+i] = active_cfg[pla_lit_pos(N_IN, N_TERM, N_OUT, t, i, 0)];
            assign lit_comp[t*N_IN+i] = active_cfg[pla_lit_pos(N_IN, N_TERM, N_OUT, t, i, 1)];
        end
        for (genvar o = 0; o < N_OUT; o++) begin : g_conn_o
            assign conn[o*N_TERM+t] = active_cfg[pla_conn_pos(N_OUT, t, o)];
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_pol
        assign pol[o] = active_cfg[pla_pol_pos(o)];
    end

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec   (in_vec),
        .lit_true (lit_true),
        .lit_comp (lit_comp),
        .term_vec (term_vec)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term_vec (term_vec),
        .conn     (conn),
        .pol      (pol),
        .sum_vec  (sum_vec),
        .out_vec  (out_vec)
    );

endmodule

// File: rtl/pla_core_chk.sv
// Module: property checker for pla_core, attached by bind. Observes the
// configuration registers and the signals passed between the planes.
module pla_core_chk #(
    parameter int unsigned N_IN   = 3,
    parameter int unsigned N_TERM = 4,
    parameter int unsigned N_OUT  = 3,
    parameter int unsigned CFG_W  = 39
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    commit,
    input logic [CFG_W-1:0]        shadow_cfg,
    input logic [CFG_W-1:0]        active_cfg,
    input logic [N_TERM*N_IN-1:0]  lit_true,
    input logic [N_TERM*N_IN-1:0]  lit_comp,
    input logic [N_OUT*N_TERM-1:0] conn,
    input logic [N_OUT-1:0]        pol,
    input logic [N_TERM-1:0]       term_vec,
    input logic [N_OUT-1:0]        sum_vec,
    input logic [N_OUT-1:0]        out_vec
);

    // R1: reset leaves the active word empty
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (active_cfg == '0));

    // R7: no commit, no change of the active word
    assert_hold_without_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_cfg));

    // R7: commit copies the word staged before the edge
    assert_commit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_cfg == $past(shadow_cfg)));

    for (genvar t = 0; t < N_TERM; t++) begin : g_chk_t
        // R3: conflicting literals force the term low
        assert_conflict_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (|(lit_true[t*N_IN +: N_IN] & lit_comp[t*N_IN +: N_IN])) |-> !term_vec[t]);
        // R2: an empty term is 1
        assert_empty_term_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((lit_true[t*N_IN +: N_IN] | lit_comp[t*N_IN +: N_IN]) == '0) |-> term_vec[t]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk_o
        // R4: no connections, sum is 0
        assert_no_conn_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (conn[o*N_TERM +: N_TERM] == '0) |-> !sum_vec[o]);
        // R5: inverted empty output reads 1
        assert_inverted_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pol[o] && (conn[o*N_TERM +: N_TERM] == '0)) |-> out_vec[o]);
        // R4: an active connected term drives the output to the non-inverted level
        assert_term_routing_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (|(conn[o*N_TERM +: N_TERM] & term_vec)) |-> (out_vec[o] != pol[o]));
    end

endmodule

bind pla_core pla_core_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .CFG_W  (CFG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .shadow_cfg (shadow_cfg),
    .active_cfg (active_cfg),
    .lit_true   (lit_true),
    .lit_comp   (lit_comp),
    .conn       (conn),
    .pol        (pol),
    .term_vec   (term_vec),
    .sum_vec    (sum_vec),
    .out_vec    (out_vec)
);

// File: tb/sim_pla_core.sv
// Directed bench for pla_core: one task per scenario, each checking itself.
module sim_pla_core;

    localparam int CW = 39;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic       cfg_sdi = 1'b0;
    logic       commit = 1'b0;
    logic [2:0] in_vec = 3'd0;
    logic [2:0] out_vec;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    pla_core u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .cfg_sdi (cfg_sdi),
        .commit  (commit),
        .in_vec  (in_vec),
        .out_vec (out_vec)
    );

    always #10 clk = ~clk;

    // Layout from R6
    function automatic int pos_pol(int o);                return o; endfunction
    function automatic int pos_conn(int t, int o);        return 3 + 3*t + o; endfunction
    function automatic int pos_lit(int t, int i, int neg); return 15 + 6*t + 2*i + neg; endfunction

    task automatic check(string req, logic [2:0] got, logic [2:0] exp, int v);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s in=%0d actual=%b expected=%b", req, v, got, exp);
        end
    endtask

    task automatic shift_word(logic [CW-1:0] w);
        for (int b = CW-1; b >= 0; b--) begin
            @(negedge clk);
            load_en = 1'b1;
            cfg_sdi = w[b];
        end
        @(negedge clk);
        load_en = 1'b0;
        cfg_sdi = 1'b0;
    endtask

    task automatic pulse_commit();
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic load_word(logic [CW-1:0] w);
        shift_word(w);
        pulse_commit();
    endtask

    // Sample at negedge+2 after driving inputs; no edge in between
    task automatic apply(int v);
        @(negedge clk);
        in_vec = 3'(v);
        #2;
    endtask

    function automatic logic [CW-1:0] word_r9();
        logic [CW-1:0] w = '0;
        w[pos_lit(0,2,0)] = 1; w[pos_lit(0,1,1)] = 1;                         // A B'
        w[pos_lit(1,2,0)] = 1; w[pos_lit(1,0,0)] = 1;                         // A C
        w[pos_lit(2,2,1)] = 1; w[pos_lit(2,1,0)] = 1; w[pos_lit(2,0,1)] = 1;  // A' B C'
        w[pos_lit(3,1,0)] = 1; w[pos_lit(3,0,0)] = 1;                         // B C
        w[pos_conn(0,0)] = 1; w[pos_conn(1,0)] = 1; w[pos_conn(2,0)] = 1;
        w[pos_conn(1,1)] = 1; w[pos_conn(3,1)] = 1; w[pos_pol(1)] = 1;
        w[pos_pol(2)] = 1;                                                    // empty, inverted
        return w;
    endfunction

    function automatic logic [2:0] exp_r9(int v);
        logic a = v[2], b = v[1], c = v[0];
        return {1'b1, ~((a&c)|(b&c)), (a&~b)|(a&c)|(~a&b&~c)};
    endfunction

    function automatic logic [CW-1:0] word_r10();
        logic [CW-1:0] w = '0;
        w[pos_lit(0,1,0)] = 1; w[pos_lit(0,0,0)] = 1;                         // B C
        w[pos_lit(1,2,0)] = 1; w[pos_lit(1,1,1)] = 1; w[pos_lit(1,0,0)] = 1;  // A B' C
        w[pos_lit(2,2,0)] = 1; w[pos_lit(2,1,0)] = 1; w[pos_lit(2,0,1)] = 1;  // A B C'
        w[pos_lit(3,1,1)] = 1; w[pos_lit(3,0,1)] = 1;                         // B' C'
        w[pos_conn(0,0)] = 1; w[pos_conn(1,0)] = 1; w[pos_conn(2,0)] = 1;
        w[pos_conn(1,1)] = 1; w[pos_conn(2,1)] = 1; w[pos_conn(3,1)] = 1;
        w[pos_pol(1)] = 1;
        w[pos_conn(0,2)] = 1; w[pos_pol(2)] = 1;                              // NAND(B,C)
        return w;
    endfunction

    function automatic logic [2:0] exp_r10(int v);
        logic [7:0] f1 = 8'hE8;  // minterms 3,5,6,7
        logic [7:0] f2 = 8'h8E;  // minterms 1,2,3,7
        return {~(v[1] & v[0]), f2[v], f1[v]};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic test_reset_state();
        do_reset();
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R1 reset", out_vec, 3'b000, v);
        end
    endtask

    task automatic test_example_r9();
        load_word(word_r9());
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R9 F1/F2 example", out_vec, exp_r9(v), v);
        end
    endtask

    task automatic test_minterms_r10();
        load_word(word_r10());
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R10 minterm sets", out_vec, exp_r10(v), v);
        end
    endtask

    task automatic test_conflict_and_empty();
        logic [CW-1:0] w = '0;
        w[pos_lit(0,1,0)] = 1; w[pos_lit(0,1,1)] = 1;   // B B' in term 0
        w[pos_conn(0,0)] = 1;                           // out0 = term0
        w[pos_conn(1,1)] = 1;                           // out1 = empty term1
        w[pos_conn(0,2)] = 1; w[pos_pol(2)] = 1;        // out2 = ~term0
        load_word(w);
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R3 conflict term / R2 empty term", out_vec, 3'b110, v);
        end
    endtask

    task automatic test_literal_walk();
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 3; i++)
                for (int neg = 0; neg < 2; neg++)
                    for (int o = 0; o < 3; o++) begin
                        logic [CW-1:0] w = '0;
                        w[pos_lit(t,i,neg)] = 1;
                        w[pos_conn(t,o)] = 1;
                        load_word(w);
                        for (int v = 0; v < 8; v++) begin
                            logic [2:0] e = '0;
                            e[o] = v[i] ^ neg[0];
                            apply(v);
                            check("R2 R4 R6 literal walk", out_vec, e, v);
                        end
                    end
    endtask

    task automatic test_polarity_r5();
        logic [CW-1:0] w = '0;
        w[pos_lit(2,0,0)] = 1;                                 // term2 = C
        w[pos_conn(2,0)] = 1; w[pos_conn(2,1)] = 1; w[pos_conn(2,2)] = 1;
        w[pos_pol(1)] = 1;
        load_word(w);
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R5 inversion", out_vec, {v[0], ~v[0], v[0]}, v);
        end
    endtask

    task automatic test_staging_r7();
        load_word(word_r10());
        shift_word(word_r9());
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R7 no commit keeps old function", out_vec, exp_r10(v), v);
        end
        @(negedge clk);
        pulse_commit();
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R7 commit applies staged word", out_vec, exp_r9(v), v);
        end
    endtask

    task automatic test_comb_r8();
        load_word(word_r9());
        @(negedge clk);
        in_vec = 3'd5;
        #1;
        in_vec = 3'd2;
        #1;
        check("R8 combinational path", out_vec, exp_r9(2), 2);
        in_vec = 3'd6;
        #1;
        check("R8 combinational path", out_vec, exp_r9(6), 6);
    endtask

    task automatic test_reset_clears_staging_r1();
        shift_word(word_r10());
        do_reset();
        @(negedge clk);
        pulse_commit();
        for (int v = 0; v < 8; v++) begin
            apply(v);
            check("R1 reset clears staging", out_vec, 3'b000, v);
        end
    endtask

    initial begin
        test_reset_state();
        test_example_r9();
        test_minterms_r10();
        test_conflict_and_empty();
        test_polarity_r5();
        test_staging_r7();
        test_comb_r8();
        test_literal_walk();
        test_reset_clears_staging_r1();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule